// File: doc/BRIEF.md
# Programmed-I/O Register Transaction Sequencer

This block is a host-side master for single 16-bit register accesses to a storage-style slave on a parallel bus that uses fast programmed-I/O timing. A client on the system side offers one request at a time: the register address, a slave select, a read/write flag and the write data. The sequencer places the address and a chip select on the device bus and holds them for a setup period. It then pulses the read or write strobe. After the strobe it keeps address and data steady for a hold period and idles until a minimum cycle length has passed. It then reports completion with a one-cycle done pulse. For a read, the captured word is presented at the same moment.

All durations are counted in system clocks. Four configuration inputs give the setup, strobe, hold and cycle minimums. They are latched into internal registers when a request is accepted, so any value that meets the slave's nanosecond limits at the chosen clock can be used. The slave can stretch the strobe by holding its ready line low. A fixed timeout, in clocks, ends a stretched strobe and flags an error with done. The device data bus is split into an output, an output enable and an input, for a pad ring that combines them.

Top module: `pio_host_seq`

## Requirements
- R1: During and right after reset, both strobes and every chip select are high (inactive), the data output enable is low, done and error are low, and reqReady is high.
- R2: A request is taken on a clock edge where reqValid and reqReady are both high. From the next cycle, devAddr carries the request address and only the selected chip select (devCsN bit reqCs) is low. Both strobes stay high for exactly S setup cycles.
- R3: The strobe (devRdN for reqWrite=0, devWrN for reqWrite=1) stays low for at least P cycles. It ends after the first strobe cycle, counted from 1, that is at least P and in which devRdy is high.
- R4: When a strobe ends normally, address and chip select stay asserted with both strobes high for exactly H hold cycles.
- R5: Counted from the first setup cycle, done asserts after max(S+W+H, C) cycles, where W is the actual strobe width. Cycles beyond S+W+H are spent with all chip selects high.
- R6: A configuration count of zero acts as a count of one.
- R7: A read captures devDataIn during the first hold cycle. The word appears on rdData in the done cycle and holds until another read completes.
- R8: devDataOe is high exactly during the setup, strobe and hold cycles of a write, with devDataOut equal to the request's write data. It is never high during a read.
- R9: If devRdy is low in strobe cycle TMO_CYC (250 by default), the strobe and chip select end after that cycle. Done and error then assert together in the next cycle, with no hold or recovery, and rdData keeps its old value.
- R10: reqReady is low from the cycle after acceptance through the done cycle. reqValid in that window starts nothing and does not alter devAddr.
- R11: done is a single-cycle pulse, and error is high only in a done cycle.
- R12: The read and write strobes are never low together, and only the strobe matching the request direction is ever pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 5 | Register address |
| reqCs | input | 1 | Index of the chip select to use |
| reqWdata | input | 16 | Write data |
| cfgSetup | input | 8 | Setup cycles S |
| cfgPulse | input | 8 | Minimum strobe cycles P |
| cfgHold | input | 8 | Hold cycles H |
| cfgCycle | input | 8 | Minimum transaction cycles C |
| done | output | 1 | Transaction complete pulse |
| error | output | 1 | Ready timeout, valid with done |
| rdData | output | 16 | Last captured read word |
| devAddr | output | 5 | Device address bus |
| devCsN | output | 2 | Active-low chip selects |
| devRdN | output | 1 | Active-low read strobe |
| devWrN | output | 1 | Active-low write strobe |
| devDataOut | output | 16 | Device data bus, outbound |
| devDataOe | output | 1 | Output enable for devDataOut |
| devDataIn | input | 16 | Device data bus, inbound |
| devRdy | input | 1 | Slave ready, low stretches the strobe |

## Verification
The assertions assume that devRdy and devDataIn are already synchronous to clk. They also assume the slave changes devDataIn only while no chip select is low or after the first hold cycle. The bench slave model meets both: it updates ready and data only on the falling clock edge, and it holds its read word for as long as a chip select is low. The configuration inputs are taken to be stable only on the accepting edge. The bench therefore drives them together with reqValid, and in the refusal test it keeps a different request pending through the whole busy window.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_STROBE  = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RECOVER = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic accept;   // latch request fields
    logic selOn;    // address phase: chip select active
    logic oeOn;     // drive data bus
    logic rdOn;     // read strobe active
    logic wrOn;     // write strobe active
    logic capture;  // sample inbound data
    logic doneOn;   // completion pulse
    logic errOn;    // timeout flag
  } seq_ctl_t;

endpackage

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
  import pio_seq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TMO_CYC = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgPulse,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgCycle,
  input  logic             devRdy,
  output logic             reqReady,
  output seq_ctl_t         ctl
);

  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam int PH_W  = (CNT_W > TMO_W) ? CNT_W : TMO_W;
  localparam int EL_W  = $clog2(3 * (2 ** CNT_W) + TMO_CYC + 2);
  localparam logic [EL_W-1:0] EL_MAX = '1;

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  seq_state_t       state, nextState;
  logic [PH_W-1:0]  phaseCnt;
  logic [EL_W-1:0]  elapsed;
  logic [CNT_W-1:0] setupR, pulseR, holdR, cycleR;
  logic             isWrite, errR;

  logic [PH_W:0]    phaseNext;
  logic [EL_W:0]    elNext;
  logic             setupDone, pulseMet, holdDone, cycleMet, tmoHit;

  assign phaseNext = {1'b0, phaseCnt} + (PH_W+1)'(1);
  assign elNext    = {1'b0, elapsed} + (EL_W+1)'(1);
  assign setupDone = phaseNext >= (PH_W+1)'(setupR);
  assign pulseMet  = phaseNext >= (PH_W+1)'(pulseR);
  assign holdDone  = phaseNext >= (PH_W+1)'(holdR);
  assign tmoHit    = phaseNext >= (PH_W+1)'(TMO_CYC);
  assign cycleMet  = elNext >= (EL_W+1)'(cycleR);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (reqValid) nextState = ST_SETUP;
      ST_SETUP:   if (setupDone) nextState = ST_STROBE;
      ST_STROBE: begin
        if (devRdy && pulseMet)     nextState = ST_HOLD;
        else if (!devRdy && tmoHit) nextState = ST_DONE;
      end
      ST_HOLD:    if (holdDone) nextState = cycleMet ? ST_DONE : ST_RECOVER;
      ST_RECOVER: if (cycleMet) nextState = ST_DONE;
      ST_DONE:    nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      elapsed  <= '0;
      setupR   <= CNT_W'(1);
      pulseR   <= CNT_W'(1);
      holdR    <= CNT_W'(1);
      cycleR   <= CNT_W'(1);
      isWrite  <= 1'b0;
      errR     <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && reqValid) begin
        setupR   <= atLeastOne(cfgSetup);
        pulseR   <= atLeastOne(cfgPulse);
        holdR    <= atLeastOne(cfgHold);
        cycleR   <= atLeastOne(cfgCycle);
        isWrite  <= reqWrite;
        errR     <= 1'b0;
        elapsed  <= '0;
        phaseCnt <= '0;
      end else begin
        if (state != ST_IDLE && state != ST_DONE && elapsed != EL_MAX)
          elapsed <= elapsed + EL_W'(1);
        if (nextState != state)
          phaseCnt <= '0;
        else if (state == ST_SETUP || state == ST_STROBE || state == ST_HOLD)
          phaseCnt <= phaseCnt + PH_W'(1);
        if (state == ST_STROBE && nextState == ST_DONE)
          errR <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.accept  = (state == ST_IDLE) && reqValid;
    ctl.selOn   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    ctl.oeOn    = ctl.selOn && isWrite;
    ctl.rdOn    = (state == ST_STROBE) && !isWrite;
    ctl.wrOn    = (state == ST_STROBE) && isWrite;
    ctl.capture = (state == ST_HOLD) && (phaseCnt == '0) && !isWrite;
    ctl.doneOn  = (state == ST_DONE);
    ctl.errOn   = (state == ST_DONE) && errR;
  end

  assign reqReady = (state == ST_IDLE);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doneOn |=> !ctl.doneOn);

  // R9: ready still low at the last allowed strobe cycle ends in an error completion
  p_timeout_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && !devRdy && phaseNext == (PH_W+1)'(TMO_CYC))
      |=> (ctl.doneOn && ctl.errOn));

  // R3: a normal strobe end never happens before the programmed width
  p_pulse_min_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && devRdy && phaseNext < (PH_W+1)'(pulseR)) |=> (state == ST_STROBE));

endmodule

// File: rtl/pio_seq_dpath.sv
module pio_seq_dpath
  import pio_seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CS_NUM = 2,
  localparam int CS_W  = (CS_NUM > 1) ? $clog2(CS_NUM) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] devDataIn,
  output logic [ADDR_W-1:0] devAddr,
  output logic [CS_NUM-1:0] devCsN,
  output logic              devRdN,
  output logic              devWrN,
  output logic [DATA_W-1:0] devDataOut,
  output logic              devDataOe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrR;
  logic [CS_W-1:0]   csR;
  logic [DATA_W-1:0] wdataR, rdDataR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR   <= '0;
      csR     <= '0;
      wdataR  <= '0;
      rdDataR <= '0;
    end else begin
      if (ctl.accept) begin
        addrR  <= reqAddr;
        csR    <= reqCs;
        wdataR <= reqWdata;
      end
      if (ctl.capture) rdDataR <= devDataIn;
    end
  end

  for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
    assign devCsN[i] = !(ctl.selOn && (csR == CS_W'(i)));
  end

  assign devAddr    = addrR;
  assign devRdN     = !ctl.rdOn;
  assign devWrN     = !ctl.wrOn;
  assign devDataOut = wdataR;
  assign devDataOe  = ctl.oeOn;
  assign rdData     = rdDataR;

  // R8: the bus is never driven while the slave is asked to drive it
  p_oe_not_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    devDataOe |-> devRdN);

  // R12: strobes mutually exclusive
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !devRdN |-> devWrN);

  // R2: at most one chip select active
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~devCsN));

endmodule

// File: rtl/pio_host_seq.sv
module pio_host_seq
  import pio_seq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int CS_NUM  = 2,
  parameter int CNT_W   = 8,
  parameter int TMO_CYC = 250,
  localparam int CS_W   = (CS_NUM > 1) ? $clog2(CS_NUM) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgCycle,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] devAddr,
  output logic [CS_NUM-1:0] devCsN,
  output logic              devRdN,
  output logic              devWrN,
  output logic [DATA_W-1:0] devDataOut,
  output logic              devDataOe,
  input  logic [DATA_W-1:0] devDataIn,
  input  logic              devRdy
);

  seq_ctl_t ctl;

  pio_seq_ctrl #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cfgSetup(cfgSetup), .cfgPulse(cfgPulse), .cfgHold(cfgHold), .cfgCycle(cfgCycle),
    .devRdy(devRdy), .reqReady(reqReady), .ctl(ctl)
  );

  pio_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_NUM(CS_NUM)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqCs(reqCs),
    .reqWdata(reqWdata), .devDataIn(devDataIn), .devAddr(devAddr), .devCsN(devCsN),
    .devRdN(devRdN), .devWrN(devWrN), .devDataOut(devDataOut), .devDataOe(devDataOe),
    .rdData(rdData)
  );

  assign done  = ctl.doneOn;
  assign error = ctl.errOn;

  // R10: while busy, the address presented to the slave cannot change
  p_refuse_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(devAddr));

  // R2: a strobe only starts after a cycle with chip select already low
  p_setup_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(devRdN) || $fell(devWrN)) |-> $past(~devCsN != '0));

  // R4: after a normal strobe end the chip select is still held
  p_hold_after_r4: assert property (@(posedge clk) disable iff (!rstN)
    (($rose(devRdN) || $rose(devWrN)) && !error) |-> (~devCsN != '0));

  // R11: error flag only with done
  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

endmodule

// File: tb/tb_pio_host_seq.sv
`timescale 1ns/1ps
module tb_pio_host_seq;

  localparam int TMO = 250;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [4:0]  reqAddr = '0;
  logic [0:0]  reqCs = '0;
  logic [15:0] reqWdata = '0;
  logic [7:0]  cfgSetup = 8'd1, cfgPulse = 8'd1, cfgHold = 8'd1, cfgCycle = 8'd1;
  logic        done, error;
  logic [15:0] rdData;
  logic [4:0]  devAddr;
  logic [1:0]  devCsN;
  logic        devRdN, devWrN;
  logic [15:0] devDataOut;
  logic        devDataOe;
  logic [15:0] devDataIn;
  logic        devRdy = 1'b1;

  int checks = 0;
  int fails  = 0;

  int          sCnt = 0;
  int          rdyLow = 0;
  logic [15:0] rdVal = 16'h0000;

  always #2.5 clk = ~clk;

  pio_host_seq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqCs(reqCs), .reqWdata(reqWdata), .cfgSetup(cfgSetup),
    .cfgPulse(cfgPulse), .cfgHold(cfgHold), .cfgCycle(cfgCycle), .done(done), .error(error),
    .rdData(rdData), .devAddr(devAddr), .devCsN(devCsN), .devRdN(devRdN), .devWrN(devWrN),
    .devDataOut(devDataOut), .devDataOe(devDataOe), .devDataIn(devDataIn), .devRdy(devRdy)
  );

  // Slave model: ready low for the first rdyLow strobe cycles, data valid while selected.
  always @(negedge clk) begin
    if (!devRdN || !devWrN) begin
      sCnt = sCnt + 1;
      devRdy <= (sCnt > rdyLow);
    end else begin
      sCnt = 0;
      devRdy <= 1'b1;
    end
  end
  assign devDataIn = (&devCsN) ? 16'hDEAD : rdVal;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic runTxn(input bit wr, input logic [4:0] a, input bit cs,
                        input logic [15:0] wd, input logic [15:0] rv,
                        input int s, input int p, input int h, input int c,
                        input int rl, input bit busy, input string nm);
    logic [15:0] prevRd;
    int es, ep, eh, ec, expStr, expTot, expHold;
    bit expErr;
    int setupC = 0, strobeC = 0, holdC = 0, total = 0, phase = 0;
    int csBad = 0, addrBad = 0, oeBad = 0, dataBad = 0, dirBad = 0, busyBad = 0;
    bit csLow, stb;
    es = (s == 0) ? 1 : s;
    ep = (p == 0) ? 1 : p;
    eh = (h == 0) ? 1 : h;
    ec = (c == 0) ? 1 : c;
    expErr  = (rl >= TMO);
    expStr  = expErr ? TMO : imax(ep, rl + 1);
    expHold = expErr ? 0 : eh;
    expTot  = expErr ? es + TMO : imax(es + expStr + eh, ec);

    @(negedge clk);
    prevRd   = rdData;
    rdyLow   = rl;
    rdVal    = rv;
    reqWrite = wr;
    reqAddr  = a;
    reqCs    = cs;
    reqWdata = wd;
    cfgSetup = 8'(s);
    cfgPulse = 8'(p);
    cfgHold  = 8'(h);
    cfgCycle = 8'(c);
    reqValid = 1'b1;
    chk(reqReady == 1'b1, {"R10 idle ready ", nm}, int'(reqReady), 1);
    @(negedge clk);
    if (busy) reqAddr = a ^ 5'h1F;
    else reqValid = 1'b0;

    for (int g = 0; g < 3000; g++) begin
      if (done) break;
      csLow = !(&devCsN);
      stb   = !devRdN || !devWrN;
      total++;
      if (reqReady) busyBad++;
      if (csLow) begin
        if (devCsN != ~(2'b01 << cs)) csBad++;
        if (devAddr != a) addrBad++;
      end
      if (stb) begin
        phase = 1;
        strobeC++;
        if (wr && !devRdN) dirBad++;
        if (!wr && !devWrN) dirBad++;
      end else if (phase == 0) begin
        if (csLow) setupC++;
      end else begin
        phase = 2;
        if (csLow) holdC++;
      end
      if (devDataOe && (!wr || !csLow)) oeBad++;
      if (wr && csLow && !devDataOe) oeBad++;
      if (devDataOe && devDataOut != wd) dataBad++;
      @(negedge clk);
    end

    chk(done == 1'b1, {"R5 done seen ", nm}, int'(done), 1);
    chk(error == expErr, {"R9 error flag ", nm}, int'(error), int'(expErr));
    chk(reqReady == 1'b0, {"R10 busy in done cycle ", nm}, int'(reqReady), 0);
    if (!wr && !expErr) chk(rdData == rv, {"R7 read data ", nm}, int'(rdData), int'(rv));
    if (expErr) chk(rdData == prevRd, {"R9 read data kept ", nm}, int'(rdData), int'(prevRd));
    chk(setupC == es, {"R2 setup cycles ", nm}, setupC, es);
    chk(strobeC == expStr, {"R3 strobe cycles ", nm}, strobeC, expStr);
    chk(holdC == expHold, {"R4 hold cycles ", nm}, holdC, expHold);
    chk(total == expTot, {"R5 total cycles ", nm}, total, expTot);
    chk(csBad == 0 && addrBad == 0, {"R2 select/address ", nm}, csBad + addrBad, 0);
    chk(oeBad == 0 && dataBad == 0, {"R8 output enable/data ", nm}, oeBad + dataBad, 0);
    chk(dirBad == 0, {"R12 strobe direction ", nm}, dirBad, 0);
    chk(busyBad == 0, {"R10 ready low while busy ", nm}, busyBad, 0);
    if (busy) reqValid = 1'b0;

    @(negedge clk);
    chk(done == 1'b0 && error == 1'b0, {"R11 done pulse width ", nm}, int'(done), 0);
    chk(reqReady == 1'b1, {"R10 ready after done ", nm}, int'(reqReady), 1);
    if (busy) begin
      @(negedge clk);
      @(negedge clk);
      chk(&devCsN, {"R10 refused request not run ", nm}, int'(devCsN), 3);
      chk(devAddr == a, {"R10 address unchanged ", nm}, int'(devAddr), int'(a));
    end
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    chk(devRdN && devWrN, "R1 strobes high", int'({devRdN, devWrN}), 3);
    chk(&devCsN, "R1 chip selects high", int'(devCsN), 3);
    chk(!devDataOe, "R1 oe low", int'(devDataOe), 0);
    chk(!done && !error, "R1 done/error low", int'({done, error}), 0);
  endtask

  task automatic testBasicWrite();
    runTxn(1'b1, 5'h07, 1'b0, 16'hA55A, 16'h0000, 2, 14, 2, 0, 0, 1'b0, "write basic");
  endtask

  task automatic testBasicRead();
    runTxn(1'b0, 5'h12, 1'b1, 16'h0000, 16'h3C96, 5, 14, 1, 15, 0, 1'b0, "read cs1");
  endtask

  task automatic testCycleMin();
    runTxn(1'b0, 5'h03, 1'b0, 16'h0000, 16'h1234, 1, 3, 2, 40, 0, 1'b0, "read long cycle");
  endtask

  task automatic testZeroCounts();
    // R6: all counts zero behave as one
    runTxn(1'b1, 5'h1F, 1'b1, 16'hFFFF, 16'h0000, 0, 0, 0, 0, 0, 1'b0, "R6 zero counts");
  endtask

  task automatic testReadyStretch();
    runTxn(1'b1, 5'h0A, 1'b0, 16'h0F0F, 16'h0000, 3, 4, 2, 0, 20, 1'b0, "write stretched");
    runTxn(1'b0, 5'h0B, 1'b0, 16'h0000, 16'hBEEF, 1, 30, 1, 0, 5, 1'b0, "read ready early");
  endtask

  task automatic testTimeout();
    runTxn(1'b0, 5'h15, 1'b1, 16'h0000, 16'h7777, 2, 4, 3, 0, 1000, 1'b0, "read timeout");
  endtask

  task automatic testBusyRefuse();
    runTxn(1'b1, 5'h06, 1'b1, 16'hC001, 16'h0000, 2, 6, 2, 20, 3, 1'b1, "busy refuse");
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicWrite();
    testBasicRead();
    testCycleMin();
    testZeroCounts();
    testReadyStretch();
    testTimeout();
    testBusyRefuse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule